// File: doc/BRIEF.md
# Barrel Issue Scheduler

This block chooses, on every clock, at most one hardware thread to issue from. It keeps a program counter and a small amount of wait state for each thread slot. It picks among the eligible slots in rotating order, so the latency of any one thread is covered by the other threads that are in flight. Threads are started with a create command that loads a start address. They are stopped with a kill command. An external per-thread ready mask lets a synchronization unit hold a thread back.

When the datapath finds that the instruction issuing this cycle is a memory operation, it raises a memory request tagged with the thread and a lookahead value. The lookahead is the number of further instructions that thread may issue before the reply must be back. The scheduler counts replies outstanding per thread and spends the credit as the thread issues. It takes the thread out of rotation only when the credit is gone and a reply is still missing. A tagged response reduces the outstanding count, and the thread returns to rotation on the following cycle.

Top module: `barrel_issue_sched`

## Requirements
- R1: After reset no thread is active, `issue_valid` is 0 and `idle` is 1.
- R2: A thread created with start address P issues with `issue_pc` = P. Each later issue of that thread presents the previous address plus `PC_STEP` (default 8). A thread becomes eligible on the cycle after its create is sampled.
- R3: At most one thread issues per cycle. `idle` is 1 exactly when no thread is eligible, and then `issue_valid` is 0.
- R4: Among eligible threads the grant rotates in increasing thread ID order, wrapping from the highest ID to the lowest, starting after the last granted thread. With k threads eligible, each issues once every k cycles.
- R5: A thread whose bit in `thr_ready` is 0 is skipped while the other eligible threads keep issuing.
- R6: A memory request with lookahead L, for a thread with nothing outstanding, lets that thread issue exactly L more instructions. The thread is then blocked until the reply comes back.
- R7: A response tagged with a blocked thread's ID, clearing its last outstanding reply, makes it eligible in the cycle after the response is sampled, and not in the response cycle.
- R8: With several replies outstanding, the remaining credit is the smaller of the current credit and the new request's lookahead. The thread stays blocked until every outstanding reply has returned.
- R9: A killed thread does not issue from the next cycle on, and its outstanding count is cleared. When a kill and a create name the same thread in one cycle, the kill wins.
- R10: A response for a thread with no reply outstanding has no effect. A later request with lookahead 0 still blocks that thread until one response arrives.
- R11: A memory request with lookahead 0 blocks its thread from the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| create_valid | input | 1 | Start a thread |
| create_id | input | TID_W | Thread to start |
| create_pc | input | PC_W | Start address |
| kill_valid | input | 1 | Stop a thread |
| kill_id | input | TID_W | Thread to stop |
| thr_ready | input | NUM_THREADS | Per-thread external readiness |
| mem_req_valid | input | 1 | Issued instruction is a memory operation |
| mem_req_tid | input | TID_W | Thread of that memory operation |
| mem_req_la | input | LA_W | Lookahead of that memory operation |
| mem_rsp_valid | input | 1 | Memory reply returned |
| mem_rsp_tid | input | TID_W | Thread the reply belongs to |
| issue_valid | output | 1 | A thread issues this cycle |
| issue_tid | output | TID_W | Issuing thread |
| issue_pc | output | PC_W | Address of the issued instruction |
| idle | output | 1 | No thread eligible this cycle |

## Verification
On every cycle, the assertions check the following: each grant goes to an eligible thread, and the grant never goes to a thread whose credit is spent while a reply is pending. `idle` matches an empty eligibility vector. A grant follows directly after the previous one when that successor is eligible. A killed thread is not granted on the next cycle. Consecutive grants of one thread advance the address by the step. Only the bench scenarios can show the exact issue counts allowed by a lookahead, the one-cycle return after a response, min-combining of several requests, kill winning over create, and stray responses being ignored.

// File: rtl/bis_pkg.sv
package bis_pkg;

   // How a thread with outstanding memory replies is treated.
   typedef enum logic {
      WAIT_CREDIT  = 1'b0,   // keep issuing until lookahead credit is spent
      WAIT_BLOCKED = 1'b1    // stop issuing as soon as any reply is pending
   } wait_policy_e;

   localparam int unsigned BIS_LA_W_DFLT  = 3;
   localparam int unsigned BIS_CNT_W_DFLT = 4;

endpackage

// File: rtl/bis_thread_ctx.sv
module bis_thread_ctx
   import bis_pkg::*;
#(
   parameter int unsigned  PC_W    = 32,
   parameter int unsigned  PC_STEP = 8,
   parameter int unsigned  LA_W    = BIS_LA_W_DFLT,
   parameter int unsigned  CNT_W   = BIS_CNT_W_DFLT,
   parameter wait_policy_e POLICY  = WAIT_CREDIT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             create_hit,
   input  logic [PC_W-1:0]  create_pc,
   input  logic             kill_hit,
   input  logic             ext_ready,
   input  logic             issue_hit,
   input  logic             req_hit,
   input  logic [LA_W-1:0]  req_la,
   input  logic             rsp_hit,
   output logic             elig,
   output logic [PC_W-1:0]  pc,
   output logic [CNT_W-1:0] pend,
   output logic [LA_W-1:0]  credit
);

   localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

   logic             act_q;
   logic [PC_W-1:0]  pc_q;
   logic [CNT_W-1:0] pend_q, pend_d;
   logic [LA_W-1:0]  cred_q, cred_d, cred_base;
   logic             pend_dec, pend_inc, pend_left;
   logic             may_issue;

   assign pend_dec  = rsp_hit && (pend_q != '0);
   assign pend_inc  = req_hit && act_q;
   assign pend_left = (pend_q - CNT_W'(pend_dec)) != '0;

   always_comb begin
      pend_d = pend_q;
      if (pend_inc && !pend_dec)      pend_d = pend_q + 1'b1;
      else if (!pend_inc && pend_dec) pend_d = pend_q - 1'b1;
   end

   // Credit is only meaningful while replies are pending.
   always_comb begin
      cred_base = cred_q;
      if (issue_hit && (pend_q != '0) && (cred_q != '0))
         cred_base = cred_q - 1'b1;
      cred_d = cred_base;
      if (pend_inc) begin
         if (!pend_left)             cred_d = req_la;
         else if (req_la < cred_base) cred_d = req_la;
      end
   end

   generate
      if (POLICY == WAIT_CREDIT) begin : g_credit
         assign may_issue = (pend_q == '0) || (cred_q != '0);
      end else begin : g_block
         assign may_issue = (pend_q == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         pc_q   <= '0;
         pend_q <= '0;
         cred_q <= '0;
      end else if (kill_hit) begin
         act_q  <= 1'b0;
         pend_q <= '0;
         cred_q <= '0;
      end else if (create_hit) begin
         act_q  <= 1'b1;
         pc_q   <= create_pc;
         pend_q <= '0;
         cred_q <= '0;
      end else begin
         if (issue_hit) pc_q <= pc_q + STEP_V;
         pend_q <= pend_d;
         cred_q <= cred_d;
      end
   end

   assign elig   = act_q && ext_ready && may_issue;
   assign pc     = pc_q;
   assign pend   = pend_q;
   assign credit = cred_q;

endmodule

// File: rtl/bis_rr_arbiter.sv
module bis_rr_arbiter #(
   parameter int unsigned NUM   = 128,
   parameter int unsigned TID_W = $clog2(NUM)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM-1:0]   req,
   output logic             grant_valid,
   output logic [TID_W-1:0] grant_id
);

   logic [TID_W-1:0] last_q;
   logic             hi_found, lo_found;
   logic [TID_W-1:0] hi_id, lo_id;

   // Scan downward so the last hit is the lowest index; "hi" only counts
   // indices above the last grant, "lo" counts all of them (wrap case).
   always_comb begin
      hi_found = 1'b0;
      lo_found = 1'b0;
      hi_id    = '0;
      lo_id    = '0;
      for (int i = NUM - 1; i >= 0; i--) begin
         if (req[i]) begin
            lo_found = 1'b1;
            lo_id    = TID_W'(i);
            if (TID_W'(i) > last_q) begin
               hi_found = 1'b1;
               hi_id    = TID_W'(i);
            end
         end
      end
   end

   assign grant_valid = lo_found;
   assign grant_id    = hi_found ? hi_id : lo_id;

   always_ff @(posedge clk) begin
      if (!rst_n)           last_q <= TID_W'(NUM - 1);
      else if (grant_valid) last_q <= grant_id;
   end

endmodule

// File: rtl/barrel_issue_sched.sv
module barrel_issue_sched
   import bis_pkg::*;
#(
   parameter int unsigned  NUM_THREADS = 128,
   parameter int unsigned  PC_W        = 32,
   parameter int unsigned  PC_STEP     = 8,
   parameter int unsigned  LA_W        = BIS_LA_W_DFLT,
   parameter int unsigned  CNT_W       = BIS_CNT_W_DFLT,
   parameter wait_policy_e POLICY      = WAIT_CREDIT,
   localparam int unsigned TID_W       = $clog2(NUM_THREADS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   create_valid,
   input  logic [TID_W-1:0]       create_id,
   input  logic [PC_W-1:0]        create_pc,
   input  logic                   kill_valid,
   input  logic [TID_W-1:0]       kill_id,
   input  logic [NUM_THREADS-1:0] thr_ready,
   input  logic                   mem_req_valid,
   input  logic [TID_W-1:0]       mem_req_tid,
   input  logic [LA_W-1:0]        mem_req_la,
   input  logic                   mem_rsp_valid,
   input  logic [TID_W-1:0]       mem_rsp_tid,
   output logic                   issue_valid,
   output logic [TID_W-1:0]       issue_tid,
   output logic [PC_W-1:0]        issue_pc,
   output logic                   idle
);

   generate
      if (NUM_THREADS < 2 || (NUM_THREADS & (NUM_THREADS - 1)) != 0) begin : g_bad_num
         $error("NUM_THREADS must be a power of two, at least 2");
      end
      if (LA_W < 1 || CNT_W < 2) begin : g_bad_width
         $error("LA_W must be >= 1 and CNT_W >= 2");
      end
      if (PC_STEP == 0 || PC_W < 2) begin : g_bad_pc
         $error("PC_STEP must be non-zero and PC_W >= 2");
      end
   endgenerate

   logic [NUM_THREADS-1:0]            elig_vec;
   logic [NUM_THREADS-1:0][PC_W-1:0]  pc_vec;
   logic [NUM_THREADS-1:0][CNT_W-1:0] pend_vec;
   logic [NUM_THREADS-1:0][LA_W-1:0]  credit_vec;
   logic                              grant_valid;
   logic [TID_W-1:0]                  grant_id;

   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
         localparam logic [TID_W-1:0] ID = TID_W'(t);
         logic cre_hit, kil_hit, iss_hit, req_hit, rsp_hit;

         assign cre_hit = create_valid  && (create_id   == ID);
         assign kil_hit = kill_valid    && (kill_id     == ID);
         assign iss_hit = grant_valid   && (grant_id    == ID);
         assign req_hit = mem_req_valid && (mem_req_tid == ID);
         assign rsp_hit = mem_rsp_valid && (mem_rsp_tid == ID);

         bis_thread_ctx #(
            .PC_W    (PC_W),
            .PC_STEP (PC_STEP),
            .LA_W    (LA_W),
            .CNT_W   (CNT_W),
            .POLICY  (POLICY)
         ) u_ctx (
            .clk        (clk),
            .rst_n      (rst_n),
            .create_hit (cre_hit),
            .create_pc  (create_pc),
            .kill_hit   (kil_hit),
            .ext_ready  (thr_ready[t]),
            .issue_hit  (iss_hit),
            .req_hit    (req_hit),
            .req_la     (mem_req_la),
            .rsp_hit    (rsp_hit),
            .elig       (elig_vec[t]),
            .pc         (pc_vec[t]),
            .pend       (pend_vec[t]),
            .credit     (credit_vec[t])
         );
      end
   endgenerate

   bis_rr_arbiter #(
      .NUM   (NUM_THREADS),
      .TID_W (TID_W)
   ) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (elig_vec),
      .grant_valid (grant_valid),
      .grant_id    (grant_id)
   );

   assign issue_valid = grant_valid;
   assign issue_tid   = grant_id;
   assign issue_pc    = pc_vec[grant_id];
   assign idle        = !grant_valid;

endmodule

// File: rtl/bis_checker.sv
module bis_checker #(
   parameter int unsigned NUM_THREADS = 128,
   parameter int unsigned PC_W        = 32,
   parameter int unsigned PC_STEP     = 8,
   parameter int unsigned LA_W        = 3,
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned TID_W       = $clog2(NUM_THREADS)
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            create_valid,
   input logic [TID_W-1:0]                create_id,
   input logic                            kill_valid,
   input logic [TID_W-1:0]                kill_id,
   input logic                            mem_req_valid,
   input logic [TID_W-1:0]                mem_req_tid,
   input logic                            issue_valid,
   input logic [TID_W-1:0]                issue_tid,
   input logic [PC_W-1:0]                 issue_pc,
   input logic                            idle,
   input logic [NUM_THREADS-1:0]          elig_vec,
   input logic [NUM_THREADS-1:0][CNT_W-1:0] pend_vec,
   input logic [NUM_THREADS-1:0][LA_W-1:0]  credit_vec
);

   logic             prev_v;
   logic [TID_W-1:0] prev_tid;
   logic [PC_W-1:0]  prev_pc;
   logic             cre_v_q;
   logic [TID_W-1:0] cre_id_q;
   logic [TID_W-1:0] succ_tid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_v   <= 1'b0;
         prev_tid <= '0;
         prev_pc  <= '0;
         cre_v_q  <= 1'b0;
         cre_id_q <= '0;
      end else begin
         prev_v   <= issue_valid;
         prev_tid <= issue_tid;
         prev_pc  <= issue_pc;
         cre_v_q  <= create_valid;
         cre_id_q <= create_id;
      end
   end

   assign succ_tid = prev_tid + 1'b1;

   assert_idle_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (elig_vec == '0));

   assert_grant_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> elig_vec[issue_tid]);

   assert_credit_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> ((pend_vec[issue_tid] == '0) || (credit_vec[issue_tid] != '0)));

   assert_rr_successor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && prev_v && elig_vec[succ_tid]) |-> (issue_tid == succ_tid));

   assert_kill_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      kill_valid |=> !(issue_valid && issue_tid == $past(kill_id)));

   assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && prev_v && issue_tid == prev_tid &&
       !(cre_v_q && cre_id_q == issue_tid))
      |-> (issue_pc == prev_pc + PC_W'(PC_STEP)));

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (pend_vec[mem_req_tid] != '1));

endmodule

bind barrel_issue_sched bis_checker #(
   .NUM_THREADS (NUM_THREADS),
   .PC_W        (PC_W),
   .PC_STEP     (PC_STEP),
   .LA_W        (LA_W),
   .CNT_W       (CNT_W),
   .TID_W       (TID_W)
) u_bis_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .create_valid  (create_valid),
   .create_id     (create_id),
   .kill_valid    (kill_valid),
   .kill_id       (kill_id),
   .mem_req_valid (mem_req_valid),
   .mem_req_tid   (mem_req_tid),
   .issue_valid   (issue_valid),
   .issue_tid     (issue_tid),
   .issue_pc      (issue_pc),
   .idle          (idle),
   .elig_vec      (elig_vec),
   .pend_vec      (pend_vec),
   .credit_vec    (credit_vec)
);

// File: tb/barrel_issue_sched_bench.sv
module barrel_issue_sched_bench;

   localparam int N     = 128;
   localparam int PC_W  = 32;
   localparam int LA_W  = 3;
   localparam int TID_W = $clog2(N);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             create_valid = 1'b0;
   logic [TID_W-1:0] create_id = '0;
   logic [PC_W-1:0]  create_pc = '0;
   logic             kill_valid = 1'b0;
   logic [TID_W-1:0] kill_id = '0;
   logic [N-1:0]     thr_ready = '1;
   logic             mem_req_valid = 1'b0;
   logic [TID_W-1:0] mem_req_tid = '0;
   logic [LA_W-1:0]  mem_req_la = '0;
   logic             mem_rsp_valid = 1'b0;
   logic [TID_W-1:0] mem_rsp_tid = '0;
   logic             issue_valid;
   logic [TID_W-1:0] issue_tid;
   logic [PC_W-1:0]  issue_pc;
   logic             idle;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   barrel_issue_sched u_barrel_issue_sched (
      .clk(clk), .rst_n(rst_n),
      .create_valid(create_valid), .create_id(create_id), .create_pc(create_pc),
      .kill_valid(kill_valid), .kill_id(kill_id), .thr_ready(thr_ready),
      .mem_req_valid(mem_req_valid), .mem_req_tid(mem_req_tid), .mem_req_la(mem_req_la),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tid(mem_rsp_tid),
      .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc), .idle(idle)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Advance one clock; pulse inputs drop after the edge; outputs settle before sampling.
   task automatic cyc();
      @(posedge clk);
      #1;
      create_valid  = 1'b0;
      kill_valid    = 1'b0;
      mem_req_valid = 1'b0;
      mem_rsp_valid = 1'b0;
      #1;
   endtask

   task automatic do_create(input int id, input int pc);
      create_valid = 1'b1; create_id = TID_W'(id); create_pc = PC_W'(pc);
      cyc();
   endtask

   task automatic do_kill(input int id);
      kill_valid = 1'b1; kill_id = TID_W'(id);
      cyc();
   endtask

   task automatic mem_req(input int id, input int la);
      mem_req_valid = 1'b1; mem_req_tid = TID_W'(id); mem_req_la = LA_W'(la);
   endtask

   task automatic mem_rsp(input int id);
      mem_rsp_valid = 1'b1; mem_rsp_tid = TID_W'(id);
   endtask

   task automatic expect_issue(input int id, input string req);
      chk(issue_valid === 1'b1 && idle === 1'b0, req, {issue_valid, idle}, 2'b10);
      chk(issue_tid === TID_W'(id), req, issue_tid, id);
   endtask

   task automatic expect_idle(input string req);
      chk(issue_valid === 1'b0 && idle === 1'b1, req, {issue_valid, idle}, 2'b01);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) cyc();
      expect_idle("R1 reset");
      rst_n = 1'b1;
      cyc();
      expect_idle("R1 after reset");
   endtask

   task automatic t_create_pc();
      do_create(5, 'h100);
      expect_issue(5, "R2 first issue");
      chk(issue_pc === 32'h100, "R2 start pc", issue_pc, 'h100);
      cyc();
      chk(issue_pc === 32'h108, "R2 step 1", issue_pc, 'h108);
      cyc();
      chk(issue_pc === 32'h110, "R2 step 2", issue_pc, 'h110);
   endtask

   function automatic int succ3(input int id);
      case (id)
         3: return 7;
         7: return 9;
         default: return 3;
      endcase
   endfunction

   task automatic t_round_robin();
      int prev;
      kill_valid = 1'b1; kill_id = TID_W'(5);
      do_create(3, 'h300);
      do_create(7, 'h700);
      do_create(9, 'h900);
      prev = int'(issue_tid);
      chk(issue_valid === 1'b1, "R4 valid", issue_valid, 1);
      for (int k = 0; k < 6; k++) begin
         cyc();
         chk(issue_valid === 1'b1 && int'(issue_tid) == succ3(prev), "R4 rotation",
             issue_tid, succ3(prev));
         prev = int'(issue_tid);
      end
   endtask

   task automatic t_ready_mask();
      int seen7 = 0;
      int seen3 = 0;
      thr_ready[7] = 1'b0;
      #1;
      for (int k = 0; k < 6; k++) begin
         if (issue_tid == TID_W'(7)) seen7++;
         if (issue_tid == TID_W'(3)) seen3++;
         cyc();
      end
      chk(seen7 == 0, "R5 masked thread skipped", seen7, 0);
      chk(seen3 == 3, "R5 others keep issuing", seen3, 3);
      thr_ready[7] = 1'b1;
   endtask

   task automatic t_idle();
      thr_ready = '0;
      #1;
      expect_idle("R3 none ready");
      cyc();
      expect_idle("R3 none ready held");
      thr_ready = '1;
      #1;
      chk(issue_valid === 1'b1 && idle === 1'b0, "R3 ready again", {issue_valid, idle}, 2'b10);
      do_kill(3);
      do_kill(7);
      do_kill(9);
      do_create(2, 'h40);
   endtask

   task automatic t_lookahead();
      expect_issue(2, "R6 before request");
      mem_req(2, 2);
      cyc();
      expect_issue(2, "R6 lookahead issue 1");
      cyc();
      expect_issue(2, "R6 lookahead issue 2");
      cyc();
      expect_idle("R6 credit spent");
      cyc();
      expect_idle("R6 still waiting");
   endtask

   task automatic t_response();
      mem_rsp(2);
      #1;
      expect_idle("R7 response cycle");
      cyc();
      expect_issue(2, "R7 eligible next cycle");
   endtask

   task automatic t_la_zero();
      mem_req(2, 0);
      cyc();
      expect_idle("R11 zero lookahead blocks");
      mem_rsp(2);
      cyc();
      expect_issue(2, "R11 resumes");
   endtask

   task automatic t_multi();
      mem_req(2, 3);
      cyc();
      expect_issue(2, "R8 after first request");
      mem_req(2, 1);
      cyc();
      expect_issue(2, "R8 credit min");
      cyc();
      expect_idle("R8 min credit spent");
      mem_rsp(2);
      cyc();
      expect_idle("R8 one reply still out");
      mem_rsp(2);
      cyc();
      expect_issue(2, "R8 all replies back");
   endtask

   task automatic t_kill();
      do_create(4, 'h200);
      kill_valid = 1'b1; kill_id = TID_W'(2);
      do_create(2, 'h300);
      for (int k = 0; k < 3; k++) begin
         expect_issue(4, "R9 kill wins over create");
         cyc();
      end
      mem_req(4, 0);
      cyc();
      expect_idle("R9 blocked before kill");
      do_kill(4);
      expect_idle("R9 killed");
      do_create(4, 'h500);
      expect_issue(4, "R9 pending cleared by kill");
      chk(issue_pc === 32'h500, "R9 restart pc", issue_pc, 'h500);
   endtask

   task automatic t_stray();
      mem_rsp(4);
      cyc();
      expect_issue(4, "R10 stray response");
      mem_req(4, 0);
      cyc();
      expect_idle("R10 still blocks");
      mem_rsp(4);
      cyc();
      expect_issue(4, "R10 resumes after real reply");
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_create_pc();
      t_round_robin();
      t_ready_mask();
      t_idle();
      t_lookahead();
      t_response();
      t_la_zero();
      t_multi();
      t_kill();
      t_stray();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule